// File: doc/BRIEF.md
# Prescaled Countdown Timer

This block is a word-addressed timer peripheral. A host programs a prescale factor and a period through a small register bus. A start command then runs the timer for exactly prescale times period system clock cycles.

Internally one counter splits the system clock into ticks of `prescale` cycles each. A second counter counts `period` ticks down to zero. When the tick counter reaches zero, the running flag drops and a sticky expired flag rises. The host can stop the timer at any moment, which freezes the remaining count.

Tick boundaries add no cycle. A reload of the prescale counter happens in the same cycle as the tick it ends, so a setting of 18 × 1000 lasts 18000 cycles, not 19000. The block keeps no shadow copy of the configuration. Instead, the prescale register is write-protected while the timer runs, because the counter reloads from it at every tick.

Top module: `timer_core`

## Requirements
- R1: After reset the prescale register (word 2) and the period register (word 3) both read 1. The status register (word 1) reads 0 and the count register (word 4) reads 0.
- R2: A write to word 0 with bit 0 set starts the timer. The running output and status bit 0 are then high for exactly prescale × period clock cycles, starting the cycle after the write edge.
- R3: When the last tick ends, running falls, the expired output and status bit 1 go high, and the count register reads 0 until the next start.
- R4: A write to word 0 with bit 1 set clears running on the next edge and freezes the count register at the ticks still remaining. If bit 0 and bit 1 are set in the same write, the stop takes effect and the start is ignored.
- R5: A start reloads both counters from the configuration registers and clears the expired flag, including after a stop or an expiry.
- R6: A write to the prescale register while the timer runs is discarded. It changes neither the current run nor the stored value.
- R7: A write to the period register is accepted at any time. It does not change a run already in progress and applies from the next start.
- R8: A write of zero to the prescale or period register stores the value 1.
- R9: Every register write takes a single clock cycle, and the new value can be read back in the next cycle.
- R10: Read data is combinational from the address while cs is high and we is low. Words 0 and 5 to 7 read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs | input | 1 | Bus select |
| we | input | 1 | Write enable (read when low) |
| addr | input | AW (3) | Word address |
| wdata | input | DW (32) | Write data |
| rdata | output | DW (32) | Read data |
| running | output | 1 | Timer is counting |
| expired | output | 1 | Last run reached zero |

## Verification
The bench builds the block with its default 32-bit data width and 3-bit word address. This leaves room to test a long run such as 18 × 1000, where even one extra cycle per reload would add a thousand cycles. The same build covers the degenerate 1 × 1 setting, where the single tick ends in the first counting cycle. Unit values on one side paired with larger values on the other check that prescale reloads and period steps each add nothing to the total.

// File: rtl/timer_core.sv
module timer_core #(
  parameter int DW = 32,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          running,
  output logic          expired
);
  localparam logic [AW-1:0] A_CTRL = AW'(0);
  localparam logic [AW-1:0] A_STAT = AW'(1);
  localparam logic [AW-1:0] A_PRE  = AW'(2);
  localparam logic [AW-1:0] A_PER  = AW'(3);
  localparam logic [AW-1:0] A_CNT  = AW'(4);
  localparam logic [DW-1:0] ONE    = DW'(1);

  logic [DW-1:0] prescale_q, period_q, pre_cnt, tick_cnt;

  wire          wr       = cs & we;
  wire          stop_req = wr && addr == A_CTRL && wdata[1];
  wire          go_req   = wr && addr == A_CTRL && wdata[0];
  wire [DW-1:0] wval     = (wdata == '0) ? ONE : wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prescale_q <= ONE;
      period_q   <= ONE;
    end else begin
      if (wr && addr == A_PRE && !running) prescale_q <= wval;
      if (wr && addr == A_PER)             period_q   <= wval;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running  <= 1'b0;
      expired  <= 1'b0;
      pre_cnt  <= '0;
      tick_cnt <= '0;
    end else if (stop_req) begin
      running <= 1'b0;
    end else if (go_req) begin
      running  <= 1'b1;
      expired  <= 1'b0;
      pre_cnt  <= prescale_q;
      tick_cnt <= period_q;
    end else if (running) begin
      if (pre_cnt == ONE) begin
        pre_cnt  <= prescale_q;
        tick_cnt <= tick_cnt - ONE;
        if (tick_cnt == ONE) begin
          running <= 1'b0;
          expired <= 1'b1;
        end
      end else begin
        pre_cnt <= pre_cnt - ONE;
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (cs && !we) begin
      case (addr)
        A_STAT:  rdata = {{(DW-2){1'b0}}, expired, running};
        A_PRE:   rdata = prescale_q;
        A_PER:   rdata = period_q;
        A_CNT:   rdata = tick_cnt;
        default: rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/timer_core_chk.sv
module timer_core_chk #(
  parameter int DW = 32,
  parameter int AW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs,
  input logic          we,
  input logic [AW-1:0] addr,
  input logic [DW-1:0] wdata,
  input logic          running,
  input logic          expired,
  input logic [DW-1:0] prescale_q,
  input logic [DW-1:0] period_q,
  input logic [DW-1:0] pre_cnt,
  input logic [DW-1:0] tick_cnt
);
  wire ctl_wr   = cs && we && addr == '0;
  wire stop_req = ctl_wr && wdata[1];
  wire go_req   = ctl_wr && wdata[0] && !wdata[1];

  assert_cfg_nonzero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    prescale_q != '0 && period_q != '0);

  assert_run_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> tick_cnt != '0 && pre_cnt != '0);

  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    running && !ctl_wr |=> tick_cnt == $past(tick_cnt) || tick_cnt == $past(tick_cnt) - 1);

  assert_expire_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(running) && !$past(stop_req) |-> tick_cnt == '0 && expired);

  assert_stop_freeze_R4: assert property (@(posedge clk) disable iff (!rst_n)
    stop_req |=> !running && $stable(tick_cnt));

  assert_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    go_req |=> running && !expired);

  assert_pre_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    running |=> $stable(prescale_q));
endmodule

bind timer_core timer_core_chk #(.DW(DW), .AW(AW)) chk (
  .clk(clk), .rst_n(rst_n), .cs(cs), .we(we), .addr(addr), .wdata(wdata),
  .running(running), .expired(expired), .prescale_q(prescale_q),
  .period_q(period_q), .pre_cnt(pre_cnt), .tick_cnt(tick_cnt)
);

// File: tb/tb_timer_core.sv
module tb_timer_core;
  localparam int DW = 32;
  localparam int AW = 3;
  localparam int NV = 7;
  localparam int VEC [NV][2] = '{'{1, 1}, '{2, 3}, '{18, 1000}, '{5, 7},
                                 '{1, 50}, '{3, 1}, '{7, 2}};

  logic clk = 0, rst_n = 0, cs = 0, we = 0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic running, expired;
  int n_run = 0, n_fail = 0;
  logic done = 0;

  timer_core #(.DW(DW), .AW(AW)) dut (
    .clk(clk), .rst_n(rst_n), .cs(cs), .we(we), .addr(addr), .wdata(wdata),
    .rdata(rdata), .running(running), .expired(expired)
  );

  always #5 clk = ~clk;

  task automatic check(input string req, input longint act, input longint exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    cs = 1; we = 1; addr = AW'(a); wdata = DW'(d);
    @(negedge clk);
    cs = 0; we = 0;
  endtask

  task automatic rd(input int a, output longint v);
    cs = 1; we = 0; addr = AW'(a);
    #1 v = rdata;
    cs = 0;
  endtask

  task automatic run_len(input int pre_seen, output int n);
    n = pre_seen;
    while (running) begin
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    longint v, c1, c2;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    rd(2, v); check("R1 prescale", v, 1);
    rd(3, v); check("R1 period", v, 1);
    rd(1, v); check("R1 status", v, 0);
    rd(4, v); check("R1 count", v, 0);

    for (int i = 0; i < NV; i++) begin
      wr(2, VEC[i][0]);
      wr(3, VEC[i][1]);
      rd(2, v); check("R9 prescale readback", v, VEC[i][0]);
      wr(0, 1);
      run_len(0, n);
      check("R2 duration", n, VEC[i][0] * VEC[i][1]);
      rd(1, v); check("R3 status expired", v, 2);
      rd(4, v); check("R3 count zero", v, 0);
      check("R3 expired pin", expired, 1);
    end

    wr(2, 0); rd(2, v); check("R8 prescale zero", v, 1);
    wr(3, 0); rd(3, v); check("R8 period zero", v, 1);
    rd(0, v); check("R10 ctrl reads zero", v, 0);
    rd(6, v); check("R10 unmapped reads zero", v, 0);

    wr(2, 4); wr(3, 10);
    wr(0, 1);
    rd(1, v); check("R5 start clears expired", v, 1);
    repeat (9) @(negedge clk);
    wr(0, 2);
    check("R4 stop clears running", running, 0);
    rd(4, c1); check("R4 frozen count", c1, 8);
    repeat (20) @(negedge clk);
    rd(4, c2); check("R4 count stays frozen", c2, 8);
    check("R4 no expiry on stop", expired, 0);

    wr(0, 1);
    run_len(0, n); check("R5 restart after stop", n, 40);

    wr(0, 3);
    check("R4 stop wins over start", running, 0);

    wr(2, 3); wr(3, 4);
    wr(0, 1);
    wr(2, 9);
    wr(3, 2);
    run_len(2, n); check("R6 R7 run unchanged", n, 12);
    rd(2, v); check("R6 prescale write dropped", v, 3);
    rd(3, v); check("R7 period write kept", v, 2);
    wr(0, 1);
    run_len(0, n); check("R7 next run uses new period", n, 6);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule